// File: doc/BRIEF.md
# Transmit Queue Priority Scheduler

This block picks which transmit descriptor queue sends next and which transmit DMA channel takes the frame. Sixteen circular descriptor queues are each tied to one of eight channels. The tie is set by software, and several queues may share one channel. Channel 7 carries commands and always outranks the four data classes on channels 0 to 3 (background, best effort, video, voice/management). Channels 4 to 6 carry no traffic.

Software programs each queue through a small register port. A queue holds a status word with its channel, active flag, window limit, activation-enable flag and block-ack mode bit. Software also writes the queue's write pointer. Each cycle the scheduler looks at every queue that is active, holds descriptors, and whose channel reports ready. It picks the highest-priority channel among them, then picks a queue on that channel in round-robin order. The grant is combinational, and the granted queue's read pointer advances at the next clock edge.

Top module: `txq_sched`

## Requirements
- R1: After reset no grant is issued, every status word reads 0, and every read and write pointer reads 0.
- R2: A status write stores the channel in bits [2:0], the active flag in bit 3, the window limit in bits [10:4], the activation-enable flag in bit 19 and the block-ack mode in bit 20. The same layout reads back, and all other bits read 0.
- R3: A window limit written above 64 is stored and read back as 64. Values 0 to 64 are stored unchanged.
- R4: A queue whose channel is 7 always holds block-ack mode 0, whatever bit 20 was written. The grant's mode output follows the stored bit.
- R5: A queue is granted only if it is active, its read pointer differs from its write pointer, and the ready input bit of its channel is high.
- R6: An inactive queue is never granted, even while it holds descriptors.
- R7: Channel 7 is served first, then channels 3, 2, 1 and 0 in that order. Queues mapped to channels 4 to 6 are never granted.
- R8: Among the eligible queues of the served channel, the first one in ascending circular index order after the last queue granted on that channel wins. Before any grant on a channel, the search starts at queue 0.
- R9: The grant carries the queue's current read pointer as the descriptor index. On each grant that pointer advances by one modulo 256 at the next clock edge.
- R10: A write-pointer write sets the selected queue's write pointer, which reads back on the pointer port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Status word write strobe |
| cfg_q | input | 4 | Queue addressed by the status write |
| cfg_wdata | input | 32 | Status word to write |
| wp_we | input | 1 | Write-pointer write strobe |
| wp_q | input | 4 | Queue addressed by the write-pointer write |
| wp_val | input | 8 | New write pointer value |
| rd_q | input | 4 | Queue shown on the readback outputs |
| rd_status | output | 32 | Status word of queue rd_q |
| rd_rptr | output | 8 | Read pointer of queue rd_q |
| rd_wptr | output | 8 | Write pointer of queue rd_q |
| ch_ready | input | 8 | Per-channel ready to accept a frame |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_q | output | 4 | Granted queue |
| gnt_idx | output | 8 | Descriptor index (read pointer) granted |
| gnt_ch | output | 3 | Channel receiving the frame |
| gnt_ba | output | 1 | Block-ack mode of the granted queue |

## Verification
The bench runs a mixed map against a cycle model for hundreds of cycles, with a changing ready pattern. It goes after priority inversions: a design that ranked channel 0 over 3, or let the idle channels 4 to 6 through, would grant the wrong channel. A round-robin that restarted at queue 0 or failed to skip the last winner would show as a wrong queue index. A long run on the command channel drives read pointers through 255 to 0, so a pointer that saturated or stalled at the wrap would hand out a stale index or stop granting. The bench also sweeps all 128 window values to catch a missing clamp. It writes block-ack mode onto a command queue to catch a missing mode override, and gives inactive queues descriptors to catch a grant that ignores the active flag.

// File: rtl/txq_sched.sv
module txq_sched #(
  parameter int NQ     = 16,
  parameter int NCH    = 8,
  parameter int PW     = 8,
  parameter int WW     = 7,
  parameter int WMAX   = 64,
  parameter int NDATA  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(NQ)-1:0]  cfg_q,
  input  logic [31:0]            cfg_wdata,
  input  logic                   wp_we,
  input  logic [$clog2(NQ)-1:0]  wp_q,
  input  logic [PW-1:0]          wp_val,
  input  logic [$clog2(NQ)-1:0]  rd_q,
  output logic [31:0]            rd_status,
  output logic [PW-1:0]          rd_rptr,
  output logic [PW-1:0]          rd_wptr,
  input  logic [NCH-1:0]         ch_ready,
  output logic                   gnt_valid,
  output logic [$clog2(NQ)-1:0]  gnt_q,
  output logic [PW-1:0]          gnt_idx,
  output logic [$clog2(NCH)-1:0] gnt_ch,
  output logic                   gnt_ba
);
  localparam int QW = $clog2(NQ);
  localparam int CW = $clog2(NCH);
  localparam logic [CW-1:0] CMD_CH = CW'(NCH-1);

  logic [CW-1:0] q_ch   [NQ];
  logic          q_act  [NQ];
  logic [WW-1:0] q_win  [NQ];
  logic          q_aen  [NQ];
  logic          q_ba   [NQ];
  logic [PW-1:0] rptr   [NQ];
  logic [PW-1:0] wptr   [NQ];
  logic [QW-1:0] last   [NCH];

  logic [NQ-1:0]  elig;
  logic [NCH-1:0] ch_has;
  logic           sel_ok, pick_ok;
  logic [CW-1:0]  sel_ch;
  logic [QW-1:0]  pick;

  wire [CW-1:0] w_ch  = cfg_wdata[CW-1:0];
  wire [WW-1:0] w_win = (cfg_wdata[4+:WW] > WW'(WMAX)) ? WW'(WMAX) : cfg_wdata[4+:WW];

  always_comb begin
    ch_has = '0;
    for (int q = 0; q < NQ; q++) begin
      elig[q] = q_act[q] && (rptr[q] != wptr[q]) && ch_ready[q_ch[q]];
      if (elig[q]) ch_has[q_ch[q]] = 1'b1;
    end
  end

  always_comb begin
    sel_ok = 1'b0;
    sel_ch = '0;
    for (int c = 0; c < NDATA; c++)
      if (ch_has[c]) begin
        sel_ok = 1'b1;
        sel_ch = CW'(c);
      end
    if (ch_has[CMD_CH]) begin
      sel_ok = 1'b1;
      sel_ch = CMD_CH;
    end
  end

  always_comb begin
    logic [QW-1:0] idx;
    pick_ok = 1'b0;
    pick    = '0;
    for (int off = NQ; off >= 1; off--) begin
      idx = last[sel_ch] + QW'(off);
      if (elig[idx] && q_ch[idx] == sel_ch) begin
        pick_ok = 1'b1;
        pick    = idx;
      end
    end
  end

  assign gnt_valid = sel_ok && pick_ok;
  assign gnt_q     = pick;
  assign gnt_idx   = rptr[pick];
  assign gnt_ch    = sel_ch;
  assign gnt_ba    = q_ba[pick];

  assign rd_status = {11'd0, q_ba[rd_q], q_aen[rd_q], 8'd0, WW'(q_win[rd_q]), q_act[rd_q], q_ch[rd_q]};
  assign rd_rptr   = rptr[rd_q];
  assign rd_wptr   = wptr[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        q_ch[q]  <= '0;
        q_act[q] <= 1'b0;
        q_win[q] <= '0;
        q_aen[q] <= 1'b0;
        q_ba[q]  <= 1'b0;
        rptr[q]  <= '0;
        wptr[q]  <= '0;
      end
      for (int c = 0; c < NCH; c++) last[c] <= QW'(NQ-1);
    end else begin
      if (cfg_we) begin
        q_ch[cfg_q]  <= w_ch;
        q_act[cfg_q] <= cfg_wdata[3];
        q_win[cfg_q] <= w_win;
        q_aen[cfg_q] <= cfg_wdata[19];
        q_ba[cfg_q]  <= cfg_wdata[20] && (w_ch != CMD_CH);
      end
      if (wp_we) wptr[wp_q] <= wp_val;
      if (gnt_valid) begin
        rptr[pick]   <= rptr[pick] + 1'b1;
        last[sel_ch] <= pick;
      end
    end
  end

  logic          p_v;
  logic [QW-1:0] p_q;
  logic [PW-1:0] p_idx;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_v <= 1'b0; p_q <= '0; p_idx <= '0;
    end else begin
      p_v <= gnt_valid; p_q <= gnt_q; p_idx <= gnt_idx;
    end
  end

  AST_GNT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ch_ready[gnt_ch]); // R5
  AST_GNT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_idx != rd_wptr) || (rd_q != gnt_q)); // R5
  AST_NO_IDLE_CH: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_ch == CMD_CH) || (gnt_ch < CW'(NDATA))); // R7
  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    p_v |-> rptr[p_q] == p_idx + 1'b1); // R9
  AST_CMD_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_ch == CMD_CH) |-> !gnt_ba); // R4
endmodule

// File: tb/txq_sched_tb_top.sv
module txq_sched_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 0, wp_we = 0;
  logic [3:0]  cfg_q = 0, wp_q = 0, rd_q = 0;
  logic [31:0] cfg_wdata = 0;
  logic [7:0]  wp_val = 0, ch_ready = 0;
  logic [31:0] rd_status;
  logic [7:0]  rd_rptr, rd_wptr, gnt_idx;
  logic        gnt_valid, gnt_ba;
  logic [3:0]  gnt_q;
  logic [2:0]  gnt_ch;

  txq_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_q(cfg_q), .cfg_wdata(cfg_wdata),
    .wp_we(wp_we), .wp_q(wp_q), .wp_val(wp_val), .rd_q(rd_q), .rd_status(rd_status),
    .rd_rptr(rd_rptr), .rd_wptr(rd_wptr), .ch_ready(ch_ready), .gnt_valid(gnt_valid),
    .gnt_q(gnt_q), .gnt_idx(gnt_idx), .gnt_ch(gnt_ch), .gnt_ba(gnt_ba)
  );

  int n_chk = 0, n_fail = 0;
  logic [2:0] m_ch [16];
  logic       m_act[16], m_ba[16];
  logic [7:0] m_rp [16], m_wp[16];
  logic [3:0] m_last[8];
  logic       e_v, e_ba;
  logic [3:0] e_q;
  logic [2:0] e_ch;
  logic [7:0] e_idx;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input int q, input int ch, input bit act, input int win, input bit aen, input bit ba);
    logic [31:0] w, exp;
    int wc;
    @(negedge clk);
    ch_ready = 0;
    w = 32'(ch) | (32'(act) << 3) | (32'(win) << 4) | (32'(aen) << 19) | (32'(ba) << 20);
    cfg_we = 1; cfg_q = 4'(q); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 0;
    m_ch[q] = 3'(ch); m_act[q] = act; m_ba[q] = ba && (ch != 7);
    wc = (win > 64) ? 64 : win;
    exp = 32'(ch) | (32'(act) << 3) | (32'(wc) << 4) | (32'(aen) << 19) | (32'(m_ba[q]) << 20);
    rd_q = 4'(q);
    #1;
    check(rd_status == exp, "R2/R3/R4 status readback", rd_status, exp);
  endtask

  task automatic setwp(input int q, input logic [7:0] v);
    @(negedge clk);
    ch_ready = 0;
    wp_we = 1; wp_q = 4'(q); wp_val = v;
    @(negedge clk);
    wp_we = 0;
    m_wp[q] = v;
    rd_q = 4'(q);
    #1;
    check(rd_wptr == v, "R10 write pointer readback", rd_wptr, v);
  endtask

  task automatic model(input logic [7:0] rdy);
    int order [5] = '{7, 3, 2, 1, 0};
    e_v = 0; e_q = 0; e_ch = 0; e_idx = 0; e_ba = 0;
    for (int k = 0; k < 5 && !e_v; k++) begin
      for (int off = 1; off <= 16 && !e_v; off++) begin
        int q = (m_last[order[k]] + off) % 16;
        if (m_ch[q] == 3'(order[k]) && m_act[q] && m_rp[q] != m_wp[q] && rdy[order[k]]) begin
          e_v = 1; e_q = 4'(q); e_ch = 3'(order[k]); e_idx = m_rp[q]; e_ba = m_ba[q];
        end
      end
    end
  endtask

  task automatic run(input int n, input bit fixed, input logic [7:0] fpat);
    for (int i = 0; i < n; i++) begin
      logic [7:0] pat;
      @(negedge clk);
      pat = fixed ? fpat : 8'((i * 37) ^ (i >> 2) ^ 8'h5a);
      ch_ready = pat;
      #1;
      model(pat);
      check(gnt_valid == e_v, "R5/R7 grant valid", gnt_valid, e_v);
      if (e_v && gnt_valid) begin
        check({gnt_q, gnt_ch} == {e_q, e_ch}, "R7/R8 queue and channel", {gnt_q, gnt_ch}, {e_q, e_ch});
        check(gnt_idx == e_idx, "R9 descriptor index", gnt_idx, e_idx);
        check(gnt_ba == e_ba, "R4 grant mode", gnt_ba, e_ba);
      end
      if (gnt_valid) begin
        check(m_act[gnt_q], "R6 inactive queue granted", gnt_q, 0);
        check(!(gnt_ch inside {3'd4, 3'd5, 3'd6}), "R7 idle channel granted", gnt_ch, 0);
      end
      @(posedge clk);
      if (e_v) begin
        m_rp[e_q] = m_rp[e_q] + 8'd1;
        m_last[e_ch] = e_q;
      end
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int chmap [16] = '{7, 3, 2, 1, 0, 4, 5, 6, 3, 3, 2, 1, 0, 0, 7, 3};
    for (int q = 0; q < 16; q++) begin
      m_ch[q] = 0; m_act[q] = 0; m_ba[q] = 0; m_rp[q] = 0; m_wp[q] = 0;
    end
    for (int c = 0; c < 8; c++) m_last[c] = 4'd15;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    ch_ready = 8'hff;
    #1;
    check(gnt_valid == 0, "R1 no grant after reset", gnt_valid, 0);
    for (int q = 0; q < 16; q++) begin
      rd_q = 4'(q);
      #1;
      check({rd_status, rd_rptr, rd_wptr} == 48'd0, "R1 reset state", rd_status, 0);
    end
    for (int w = 0; w < 128; w++) cfg(15, 2, 1, w, w[0], w[1]);
    cfg(1, 7, 1, 10, 1, 1);
    for (int q = 0; q < 16; q++)
      cfg(q, chmap[q], !(q == 9 || q == 12), 20 + q, q[0], q[1]);
    for (int q = 0; q < 16; q++) setwp(q, 8'(5 + q * 9));
    run(400, 0, 8'h00);
    for (int k = 0; k < 3; k++) begin
      setwp(0, m_rp[0] + 8'd250);
      setwp(14, m_rp[14] + 8'd250);
      run(300, 1, 8'h80);
    end
    @(negedge clk);
    ch_ready = 0;
    for (int q = 0; q < 16; q++) begin
      rd_q = 4'(q);
      #1;
      check(rd_rptr == m_rp[q], "R9 read pointer readback", rd_rptr, m_rp[q]);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule